// File: doc/BRIEF.md
# Concurrent Input-Monitoring Self-Test Unit

This unit runs a built-in self-test on a combinational circuit under test (CUT) while the system keeps using that circuit. A pseudo-random generator holds the next wanted test vector. Each cycle, a comparator checks the functional input vector against it. When a valid input vector happens to equal the wanted vector, the CUT response of that cycle is folded into a multiple-input signature register. The generator then moves to its next vector.

If functional traffic does not supply the wanted vector within a set number of cycles, the unit takes one cycle for itself. It steers the generator's vector onto the CUT inputs through the normal/test multiplexer. It raises a busy flag to the system for that cycle and compacts the response in the same way.

After a set number of test steps the unit raises `done` and stops compacting. The final signature is left for comparison with a known-good value. An enable input switches the whole mechanism off. While it is off, functional data passes straight through and all state is frozen.

Top module: `cbist_monitor`

## Requirements
- R1: A synchronous active-low reset clears the signature to zero, lowers `done` and `test_busy`, and loads the generator with the parameter `SEED`. The first forced vector after reset is therefore `SEED`.
- R2: While enabled and not done, a cycle with `norm_valid` high and `norm_data` equal to the current generator vector is a match. On the next edge, that cycle's `cut_resp` is compacted and the generator advances. `cut_in` carries `norm_data` during a match.
- R3: The generator advances as pat_next = {pat[W-2:0], ^(pat & TAPS)}. It holds its value on every cycle that is neither a match nor a forced cycle.
- R4: A compaction computes sig_next = {sig[OW-2:0], ^(sig & SIG_TAPS)} XOR cut_resp.
- R5: After `TIMEOUT` consecutive enabled cycles without a match or forced cycle, the next enabled cycle is a forced cycle. In it, `cut_in` equals the generator vector and `test_busy` is high, for exactly one cycle, and the response is compacted.
- R6: The wait count restarts from zero after every match and every forced cycle. A forced cycle takes priority over a simultaneous match.
- R7: The signature holds its value on every cycle that is neither a match nor a forced cycle.
- R8: `done` rises after `STEPS` test steps and stays high until reset. From then on, nothing is compacted, no cycle is forced, and `cut_in` equals `norm_data`.
- R9: While `en` is low, `cut_in` equals `norm_data` and `test_busy` is low. The wait count, step count, generator and signature all hold.
- R10: A cycle with `norm_valid` low is never a match, even when `norm_data` equals the generator vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enables concurrent testing |
| norm_data | input | W | Functional input vector |
| norm_valid | input | 1 | Functional vector is valid this cycle |
| cut_resp | input | OW | Response of the circuit under test |
| cut_in | output | W | Multiplexed vector driven into the circuit under test |
| test_busy | output | 1 | A test vector is forced this cycle |
| signature | output | OW | Compacted response signature |
| done | output | 1 | Requested number of test steps completed |

## Verification
The bench builds the unit with an 8-bit vector and response, `TIMEOUT` = 4 and `STEPS` = 6. With these values, forced cycles, wait-count restarts and the end of the test all occur within a few dozen cycles. A single stimulus table therefore runs through matches, near-matches, invalid strobes, disabled stretches, two forced cycles and the behaviour after `done`.

The bench models the CUT as a fixed mixing function. It predicts the generator and signature sequences from the update rules stated in R3 and R4.

// File: rtl/cbist_pkg.sv
// Shared types for the concurrent self-test unit.
// Assumes: nothing beyond IEEE 1800-2017.
package cbist_pkg;

    // Kind of test event the controller grants in the current cycle.
    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_MATCH  = 2'd1,
        EV_INSERT = 2'd2
    } ev_e;

endpackage

// File: rtl/cbist_prpg.sv
// Pseudo-random vector generator: a shift-left LFSR that advances only
// when a test step is taken.
// Assumes: SEED is nonzero and TAPS gives a useful sequence for W.
module cbist_prpg #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h5A
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] pat
);

    logic [W-1:0] pat_q;
    logic         fb;

    // Feedback bit: parity of the tapped positions.
    always_comb fb = ^(pat_q & TAPS);

    // Load the seed on reset; shift in feedback on each test step.
    always_ff @(posedge clk) begin
        if (!rst_n)   pat_q <= SEED;
        else if (adv) pat_q <= {pat_q[W-2:0], fb};
    end

    assign pat = pat_q;

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pat_q))
        else $error("generator moved without a step");

    p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pat_q != '0)
        else $error("generator reached all-zero state");

endmodule

// File: rtl/cbist_misr.sv
// Multiple-input signature register: folds one response word per test
// step into a shift-left LFSR; holds otherwise.
// Assumes: OW >= 2.
module cbist_misr #(
    parameter int           OW       = 8,
    parameter logic [OW-1:0] SIG_TAPS = 8'h8E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [OW-1:0] resp,
    output logic [OW-1:0] sig
);

    logic [OW-1:0] sig_q;
    logic [OW-1:0] sig_d;

    // Bit 0 takes the feedback parity; the others take their lower
    // neighbour. Every cell also mixes in its own response bit.
    always_comb sig_d[0] = (^(sig_q & SIG_TAPS)) ^ resp[0];

    for (genvar i = 1; i < OW; i++) begin : g_cell
        always_comb sig_d[i] = sig_q[i-1] ^ resp[i];
    end

    // Clear on reset; update only on test-step cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)   sig_q <= '0;
        else if (cap) sig_q <= sig_d;
    end

    assign sig = sig_q;

    p_sig_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(sig_q))
        else $error("signature changed without a step");

endmodule

// File: rtl/cbist_ctrl.sv
// Test-step controller: compares functional input to the wanted vector,
// counts waiting cycles, decides when to force a vector, counts steps.
// Assumes: TIMEOUT >= 1 and STEPS >= 1.
module cbist_ctrl
    import cbist_pkg::*;
#(
    parameter int W       = 8,
    parameter int TIMEOUT = 16,
    parameter int STEPS   = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         norm_valid,
    input  logic [W-1:0] norm_data,
    input  logic [W-1:0] pat,
    output ev_e          ev,
    output logic         done
);

    localparam int WAIT_W = $clog2(TIMEOUT + 1);
    localparam int STEP_W = $clog2(STEPS + 1);

    logic [WAIT_W-1:0] wait_q;
    logic [STEP_W-1:0] step_q;
    logic              active;
    logic              hit;

    // Step count reaching the target ends the test.
    always_comb done = (step_q == STEP_W'(STEPS));

    // Comparator: a valid functional vector equal to the wanted vector.
    always_comb hit = norm_valid && (norm_data == pat);

    // Event decision: forcing takes priority over a simultaneous match.
    always_comb begin
        active = en && !done;
        if (active && wait_q == WAIT_W'(TIMEOUT)) ev = EV_INSERT;
        else if (active && hit)                   ev = EV_MATCH;
        else                                      ev = EV_IDLE;
    end

    // Wait counter: restarts on any step, counts idle enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)              wait_q <= '0;
        else if (active) begin
            if (ev != EV_IDLE)   wait_q <= '0;
            else                 wait_q <= wait_q + 1'b1;
        end
    end

    // Step counter: one per match or forced cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)              step_q <= '0;
        else if (ev != EV_IDLE)  step_q <= step_q + 1'b1;
    end

    p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q <= WAIT_W'(TIMEOUT))
        else $error("wait count beyond timeout");

    p_single_insert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev == EV_INSERT |=> ev != EV_INSERT)
        else $error("forced vector held for more than one cycle");

    p_wait_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev != EV_IDLE |=> wait_q == '0)
        else $error("wait count not restarted after a step");

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done)
        else $error("done dropped");

    p_no_step_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ev == EV_IDLE)
        else $error("step taken after done");

    p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(wait_q) && $stable(step_q))
        else $error("counters moved while disabled");

    p_valid_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !norm_valid |-> ev != EV_MATCH)
        else $error("match without valid strobe");

endmodule

// File: rtl/cbist_monitor.sv
// Concurrent input-monitoring self-test unit: takes test vectors from
// functional traffic when they match, forces one after a timeout, and
// compacts the CUT responses into a signature.
// Assumes: the CUT is combinational, so cut_resp reflects cut_in in the
// same cycle.
module cbist_monitor
    import cbist_pkg::*;
#(
    parameter int            W        = 8,
    parameter int            OW       = 8,
    parameter int            TIMEOUT  = 16,
    parameter int            STEPS    = 64,
    parameter logic [W-1:0]  TAPS     = 8'hB8,
    parameter logic [W-1:0]  SEED     = 8'h5A,
    parameter logic [OW-1:0] SIG_TAPS = 8'h8E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [W-1:0]  norm_data,
    input  logic          norm_valid,
    input  logic [OW-1:0] cut_resp,
    output logic [W-1:0]  cut_in,
    output logic          test_busy,
    output logic [OW-1:0] signature,
    output logic          done
);

    logic [W-1:0] pat;
    ev_e          ev;
    logic         step;

    cbist_prpg #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_prpg (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (step),
        .pat   (pat)
    );

    cbist_ctrl #(.W(W), .TIMEOUT(TIMEOUT), .STEPS(STEPS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .norm_valid (norm_valid),
        .norm_data  (norm_data),
        .pat        (pat),
        .ev         (ev),
        .done       (done)
    );

    cbist_misr #(.OW(OW), .SIG_TAPS(SIG_TAPS)) u_misr (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (step),
        .resp  (cut_resp),
        .sig   (signature)
    );

    // Step strobe and normal/test multiplexer select.
    always_comb begin
        step      = (ev != EV_IDLE);
        test_busy = (ev == EV_INSERT);
        cut_in    = test_busy ? pat : norm_data;
    end

    p_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (cut_in == norm_data) && !test_busy)
        else $error("disabled unit altered CUT input");

    p_done_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cut_in == norm_data)
        else $error("vector forced after done");

endmodule

// File: tb/cbist_monitor_bench.sv
// Self-checking bench: table walk plus directed reset and wait-restart tests.
module cbist_monitor_bench;

    localparam int          W        = 8;
    localparam int          OW       = 8;
    localparam int          TIMEOUT  = 4;
    localparam int          STEPS    = 6;
    localparam logic [7:0]  TAPS     = 8'hB8;
    localparam logic [7:0]  SEED     = 8'h5A;
    localparam logic [7:0]  SIG_TAPS = 8'h8E;

    // Row = {en, valid, junk}; data driven = model pattern XOR junk.
    localparam int NROWS = 25;
    localparam logic [9:0] TBL [NROWS] = '{
        {2'b11, 8'h00},  // match (R2)
        {2'b11, 8'h3C},  // near miss
        {2'b11, 8'h01},  // near miss
        {2'b11, 8'h00},  // match restarts wait (R6)
        {2'b10, 8'h00},  // equal data, valid low (R10)
        {2'b10, 8'h00},
        {2'b10, 8'h00},
        {2'b10, 8'h00},
        {2'b11, 8'h00},  // forced cycle beats match (R5, R6)
        {2'b01, 8'h00},  // disabled, equal data (R9)
        {2'b01, 8'h00},
        {2'b11, 8'hA5},
        {2'b11, 8'hA5},
        {2'b11, 8'hA5},
        {2'b00, 8'h11},  // disabled hold (R9)
        {2'b11, 8'hA5},
        {2'b11, 8'h77},  // forced (R5)
        {2'b11, 8'h00},  // match
        {2'b11, 8'h00},  // match
        {2'b11, 8'h00},  // done: no compaction (R8)
        {2'b11, 8'h42},
        {2'b11, 8'h42},
        {2'b11, 8'h42},
        {2'b11, 8'h42},
        {2'b11, 8'h42}   // past timeout, still no forcing (R8)
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [W-1:0]  norm_data = '0;
    logic          norm_valid = 1'b0;
    logic [OW-1:0] cut_resp;
    logic [W-1:0]  cut_in;
    logic          test_busy;
    logic [OW-1:0] signature;
    logic          done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Reference model state.
    logic [W-1:0]  m_pat;
    logic [OW-1:0] m_sig;
    int            m_wait;
    int            m_step;

    always #2 clk = ~clk;

    // CUT stand-in: a fixed combinational mixing function.
    function automatic logic [OW-1:0] cut_fn(input logic [W-1:0] x);
        return {x[4:0], x[7:5]} ^ (x + 8'h37);
    endfunction

    always_comb cut_resp = cut_fn(cut_in);

    cbist_monitor #(
        .W(W), .OW(OW), .TIMEOUT(TIMEOUT), .STEPS(STEPS),
        .TAPS(TAPS), .SEED(SEED), .SIG_TAPS(SIG_TAPS)
    ) u_cbist_monitor (
        .clk(clk), .rst_n(rst_n), .en(en), .norm_data(norm_data),
        .norm_valid(norm_valid), .cut_resp(cut_resp), .cut_in(cut_in),
        .test_busy(test_busy), .signature(signature), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pat = SEED; m_sig = '0; m_wait = 0; m_step = 0;
    endtask

    // Drive one cycle, check outputs, then advance model with the edge.
    task automatic apply_row(input logic e, input logic v, input logic [7:0] junk);
        logic m_done, ins, mat;
        logic [W-1:0] exp_in;
        @(negedge clk);
        en = e; norm_valid = v; norm_data = m_pat ^ junk;
        #1;
        m_done = (m_step == STEPS);
        ins    = e && !m_done && (m_wait == TIMEOUT);
        mat    = e && !m_done && !ins && v && (norm_data == m_pat);
        exp_in = ins ? m_pat : norm_data;
        check("R5 busy",      test_busy, ins);
        check("R9 cut_in",    cut_in, exp_in);
        check("R4 signature", signature, m_sig);
        check("R8 done",      done, m_done);
        if (e && !m_done) begin
            if (ins || mat) begin
                m_sig  = {m_sig[OW-2:0], ^(m_sig & SIG_TAPS)} ^ cut_fn(exp_in);
                m_pat  = {m_pat[W-2:0], ^(m_pat & TAPS)};
                m_wait = 0;
                m_step++;
            end else begin
                m_wait++;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; norm_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        // R1: reset state.
        check("R1 signature", signature, 0);
        check("R1 done", done, 0);
        check("R1 busy", test_busy, 0);

        for (int i = 0; i < NROWS; i++)
            apply_row(TBL[i][9], TBL[i][8], TBL[i][7:0]);
        check("R8 done held", done, 1);

        // R1, R3: after a mid-run reset the first forced vector is SEED.
        do_reset();
        #1;
        check("R1 signature after reset", signature, 0);
        for (int i = 0; i < TIMEOUT; i++) apply_row(1'b1, 1'b0, 8'h00);
        @(negedge clk); en = 1'b1; norm_valid = 1'b0; #1;
        check("R1 first forced vector", cut_in, SEED);
        check("R5 busy on forced", test_busy, 1);
        // model must see that same cycle: rerun it through the model path
        @(posedge clk);
        m_sig  = {m_sig[OW-2:0], ^(m_sig & SIG_TAPS)} ^ cut_fn(SEED);
        m_pat  = {SEED[W-2:0], ^(SEED & TAPS)};
        m_wait = 0; m_step = 1;
        // R3: the next wanted vector is the stepped seed; match it.
        apply_row(1'b1, 1'b1, 8'h00);
        check("R3 stepped vector", 8'(cut_in), 8'({SEED[6:0], ^(SEED & TAPS)}));
        // R6: wait restart then late match avoids forcing.
        apply_row(1'b1, 1'b1, 8'h09);
        apply_row(1'b1, 1'b1, 8'h09);
        apply_row(1'b1, 1'b1, 8'h09);
        apply_row(1'b1, 1'b1, 8'h00);   // match at wait=3 restarts (R6)
        for (int i = 0; i < TIMEOUT; i++) apply_row(1'b1, 1'b1, 8'h09);
        apply_row(1'b1, 1'b0, 8'h00);   // forced now (R5)
        // R7: idle rows keep signature stable.
        apply_row(1'b1, 1'b0, 8'h00);
        apply_row(1'b1, 1'b0, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule